// File: doc/BRIEF.md
# ECC Transaction Status Aggregator

This block gathers the per-sector results of an error-correcting decoder over one read transaction. It folds them into a single summary word for the host. The decoder reports each sector with a valid strobe, a correction count and an uncorrectable flag. A start pulse opens a transaction and an end pulse closes it.

At the close, the block publishes three results:
- the largest correction count that any correctable sector needed, saturated to the output field;
- a worst-case class for the transaction;
- a threshold alert, so that software can schedule scrubbing or retirement of the block.

A status-valid flag rises when a summary is published. A host read strobe clears it. The summary fields themselves hold until the next transaction closes. The block does not store each sector's result. It keeps only a running maximum and two sticky flags.

Top module: `ecc_txn_status`

## Requirements
- R1: After reset, `max_cnt_o` is 0, `class_o` is 2'b00, and both `stat_valid_o` and `alert_o` are 0.
- R2: `max_cnt_o` is the largest `sec_cnt_i` among the transaction's sectors that have `sec_uncor_i` low. Each count is first saturated to 2**OUT_W-1 (15 at default widths, where the input is 6 bits and the output is 4 bits).
- R3: If any sector of the transaction has `sec_uncor_i` high, `class_o` is 2'b10. The count on such a sector never enters `max_cnt_o`. The value 2'b11 never appears.
- R4: If no sector is uncorrectable and at least one sector has a non-zero count, `class_o` is 2'b01.
- R5: If no sector is uncorrectable and every count is zero, `class_o` is 2'b00 and `max_cnt_o` is 0.
- R6: The summary outputs change only on the clock edge that samples `txn_end_i`. A sector presented in that same cycle is included. Between end pulses the outputs hold, including across host reads.
- R7: `txn_start_i` discards everything accumulated before it. A sector presented in the same cycle as the start belongs to the new transaction.
- R8: `stat_valid_o` is 1 in the cycle after an end pulse. It is 0 in the cycle after an `rd_i` pulse. When `rd_i` and `txn_end_i` arrive together, the flag is set.
- R9: `alert_o` is 1 exactly when the published class is 2'b01 and the published maximum is at least `thresh_i`. The threshold is sampled in the end-pulse cycle.
- R10: When `sec_valid_i` is low, the values on `sec_cnt_i` and `sec_uncor_i` have no effect on any summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_start_i | input | 1 | Opens a transaction and clears the accumulators |
| txn_end_i | input | 1 | Closes the transaction and publishes the summary |
| sec_valid_i | input | 1 | Sector result strobe |
| sec_cnt_i | input | IN_W | Corrections applied in the sector |
| sec_uncor_i | input | 1 | The sector could not be corrected |
| thresh_i | input | OUT_W | Alert threshold for the correction count |
| rd_i | input | 1 | Host read strobe; clears the status-valid flag |
| max_cnt_o | output | OUT_W | Largest saturated count among correctable sectors |
| class_o | output | 2 | 00 clean, 01 correctable, 10 uncorrectable |
| stat_valid_o | output | 1 | A summary is waiting for the host |
| alert_o | output | 1 | The correctable maximum reached the threshold |

## Verification
A wrong accumulator shows up as a wrong `max_cnt_o` or `class_o` on the cycle right after the end pulse. The bench compares every transaction there against a model computed from the sector list.

A failed clear at start shows up one transaction later. It appears as leftover uncorrectable or large-count sectors contaminating the next summary, and the bench deliberately injects such stray sectors. Faults in the valid flag or the hold logic appear one cycle after a read strobe, where both the flag and the held fields are checked.

// File: rtl/ecc_txn_pkg.sv
package ecc_txn_pkg;
  typedef enum logic [1:0] {
    ECC_CLEAN = 2'b00,
    ECC_FIXED = 2'b01,
    ECC_FATAL = 2'b10
  } ecc_class_e;

  typedef struct packed {
    logic any_fix;
    logic any_fatal;
  } ecc_flags_t;
endpackage

// File: rtl/ecc_sat_clamp.sv
module ecc_sat_clamp #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  generate
    if (IN_W > OUT_W) begin : g_clamp
      logic ovf;
      assign ovf   = |val_i[IN_W-1:OUT_W];
      assign val_o = ovf ? {OUT_W{1'b1}} : val_i[OUT_W-1:0];
    end else if (IN_W == OUT_W) begin : g_pass
      assign val_o = val_i;
    end else begin : g_ext
      assign val_o = {{(OUT_W-IN_W){1'b0}}, val_i};
    end
  endgenerate
endmodule

// File: rtl/ecc_sector_fold.sv
module ecc_sector_fold
  import ecc_txn_pkg::*;
#(
  parameter int IN_W  = 6,
  parameter int OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic [IN_W-1:0]  cnt_i,
  input  logic             fatal_i,
  output logic [OUT_W-1:0] nxt_max_o,
  output ecc_flags_t       nxt_flags_o
);
  logic [OUT_W-1:0] run_max_q;
  ecc_flags_t       flags_q;
  logic [OUT_W-1:0] cnt_sat;
  logic [OUT_W-1:0] base_max;
  ecc_flags_t       base_flags;
  logic             take;

  ecc_sat_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clamp (
    .val_i(cnt_i),
    .val_o(cnt_sat)
  );

  // start clears first, then the same-cycle sector folds in
  assign base_max   = clr_i ? '0 : run_max_q;
  assign base_flags = clr_i ? '0 : flags_q;
  assign take       = vld_i && !fatal_i;

  always_comb begin
    nxt_max_o   = base_max;
    nxt_flags_o = base_flags;
    if (take && (cnt_sat > base_max)) nxt_max_o = cnt_sat;
    if (take && (cnt_i != '0))        nxt_flags_o.any_fix = 1'b1;
    if (vld_i && fatal_i)             nxt_flags_o.any_fatal = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_max_q <= '0;
      flags_q   <= '0;
    end else begin
      run_max_q <= nxt_max_o;
      flags_q   <= nxt_flags_o;
    end
  end
endmodule

// File: rtl/ecc_class_enc.sv
module ecc_class_enc
  import ecc_txn_pkg::*;
(
  input  ecc_flags_t flags_i,
  output ecc_class_e class_o
);
  always_comb begin
    if (flags_i.any_fatal)    class_o = ECC_FATAL;
    else if (flags_i.any_fix) class_o = ECC_FIXED;
    else                      class_o = ECC_CLEAN;
  end
endmodule

// File: rtl/ecc_summary_reg.sv
module ecc_summary_reg
  import ecc_txn_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_i,
  input  logic             rd_i,
  input  logic [OUT_W-1:0] max_i,
  input  ecc_class_e       class_i,
  input  logic [OUT_W-1:0] thr_i,
  output logic [OUT_W-1:0] max_o,
  output logic [1:0]       class_o,
  output logic             valid_o,
  output logic             alert_o
);
  logic [OUT_W-1:0] max_q;
  ecc_class_e       class_q;
  logic             valid_q;
  logic             alert_q;
  logic             alert_d;

  assign alert_d = (class_i == ECC_FIXED) && (max_i >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q   <= '0;
      class_q <= ECC_CLEAN;
      alert_q <= 1'b0;
    end else if (end_i) begin
      max_q   <= max_i;
      class_q <= class_i;
      alert_q <= alert_d;
    end
  end

  // publish wins over a same-cycle read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_q <= 1'b0;
    else if (end_i) valid_q <= 1'b1;
    else if (rd_i)  valid_q <= 1'b0;
  end

  assign max_o   = max_q;
  assign class_o = class_q;
  assign valid_o = valid_q;
  assign alert_o = alert_q;
endmodule

// File: rtl/ecc_txn_status.sv
module ecc_txn_status
  import ecc_txn_pkg::*;
#(
  parameter int IN_W  = 6,
  parameter int OUT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txn_start_i,
  input  logic             txn_end_i,
  input  logic             sec_valid_i,
  input  logic [IN_W-1:0]  sec_cnt_i,
  input  logic             sec_uncor_i,
  input  logic [OUT_W-1:0] thresh_i,
  input  logic             rd_i,
  output logic [OUT_W-1:0] max_cnt_o,
  output logic [1:0]       class_o,
  output logic             stat_valid_o,
  output logic             alert_o
);
  logic [OUT_W-1:0] fold_max;
  ecc_flags_t       fold_flags;
  ecc_class_e       fold_class;

  ecc_sector_fold #(.IN_W(IN_W), .OUT_W(OUT_W)) u_fold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (txn_start_i),
    .vld_i      (sec_valid_i),
    .cnt_i      (sec_cnt_i),
    .fatal_i    (sec_uncor_i),
    .nxt_max_o  (fold_max),
    .nxt_flags_o(fold_flags)
  );

  ecc_class_enc u_enc (
    .flags_i(fold_flags),
    .class_o(fold_class)
  );

  ecc_summary_reg #(.OUT_W(OUT_W)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .end_i  (txn_end_i),
    .rd_i   (rd_i),
    .max_i  (fold_max),
    .class_i(fold_class),
    .thr_i  (thresh_i),
    .max_o  (max_cnt_o),
    .class_o(class_o),
    .valid_o(stat_valid_o),
    .alert_o(alert_o)
  );
endmodule

// File: rtl/ecc_txn_status_chk.sv
module ecc_txn_status_chk #(
  parameter int OUT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             txn_end_i,
  input logic             rd_i,
  input logic [OUT_W-1:0] max_cnt_o,
  input logic [1:0]       class_o,
  input logic             stat_valid_o,
  input logic             alert_o
);
  AST_CLASS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_o != 2'b11); // R3
  AST_CLEAN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == 2'b00) |-> (max_cnt_o == '0)); // R5
  AST_ALERT_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> (class_o == 2'b01)); // R9
  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_end_i |=> stat_valid_o); // R8
  AST_VALID_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !txn_end_i) |=> !stat_valid_o); // R8
  AST_SUMMARY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_end_i |=> ($stable(max_cnt_o) && $stable(class_o) && $stable(alert_o))); // R6
endmodule

bind ecc_txn_status ecc_txn_status_chk #(.OUT_W(OUT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .txn_end_i   (txn_end_i),
  .rd_i        (rd_i),
  .max_cnt_o   (max_cnt_o),
  .class_o     (class_o),
  .stat_valid_o(stat_valid_o),
  .alert_o     (alert_o)
);

// File: tb/ecc_txn_status_tb_top.sv
`timescale 1ns/1ps
module ecc_txn_status_tb_top;
  localparam int IN_W  = 6;
  localparam int OUT_W = 4;
  localparam int SAT   = (1 << OUT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0, fin = 1'b0, sv = 1'b0, su = 1'b0, rd = 1'b0;
  logic [IN_W-1:0]  sc = '0;
  logic [OUT_W-1:0] thr = '0;
  logic [OUT_W-1:0] max_cnt;
  logic [1:0]       cls;
  logic             vld, alert;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int unsigned rs = 32'h1234_5678;
  int sec_cnt[16];
  bit sec_unc[16];

  always #2 clk = ~clk;

  ecc_txn_status #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(start), .txn_end_i(fin),
    .sec_valid_i(sv), .sec_cnt_i(sc), .sec_uncor_i(su), .thresh_i(thr),
    .rd_i(rd), .max_cnt_o(max_cnt), .class_o(cls), .stat_valid_o(vld),
    .alert_o(alert)
  );

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  task automatic garbage();
    sv = 1'b0; sc = IN_W'(rnd()); su = rnd() & 1;
  endtask

  // nsec sectors from sec_cnt/sec_unc; R7 start may share the first sector
  task automatic run_txn(input int nsec, input int t, input bit start_w_sec,
                         input bit rd_w_end, input bit stray);
    int  emax = 0;
    bit  ecor = 0, eunc = 0;
    int  ecls;
    if (stray) begin
      @(negedge clk); sv = 1'b1; sc = '1; su = rnd() & 1;
      @(negedge clk); sv = 1'b1; sc = 6'd63; su = 1'b0;
    end
    if (!start_w_sec) begin
      @(negedge clk); start = 1'b1; garbage();
    end
    for (int i = 0; i < nsec; i++) begin
      if (i > 0 && (rnd() & 3) == 0) begin
        @(negedge clk); start = 1'b0; garbage(); // R10 idle with junk
      end
      @(negedge clk);
      start = (i == 0) && start_w_sec;
      sv = 1'b1; sc = IN_W'(sec_cnt[i]); su = sec_unc[i];
      fin = (i == nsec - 1); rd = fin && rd_w_end; thr = OUT_W'(t);
      if (sec_unc[i]) eunc = 1;
      else begin
        if (sec_cnt[i] != 0) ecor = 1;
        if ((sec_cnt[i] > SAT ? SAT : sec_cnt[i]) > emax)
          emax = (sec_cnt[i] > SAT) ? SAT : sec_cnt[i];
      end
    end
    @(negedge clk);
    start = 0; fin = 0; rd = 0; garbage(); thr = OUT_W'(rnd());
    ecls = eunc ? 2 : (ecor ? 1 : 0);
    chk("R2 max", max_cnt, emax);
    chk(eunc ? "R3 class" : (ecor ? "R4 class" : "R5 class"), cls, ecls);
    chk("R9 alert", alert, (ecls == 1 && emax >= t) ? 1 : 0);
    chk(rd_w_end ? "R8 end+rd valid" : "R6 valid", vld, 1);
    @(negedge clk); rd = 1'b1; garbage();
    @(negedge clk); rd = 1'b0;
    chk("R8 cleared by read", vld, 0);
    chk("R6 hold after read", max_cnt, emax);
    chk("R6 class hold", cls, ecls);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 max", max_cnt, 0);
    chk("R1 class", cls, 0);
    chk("R1 valid", vld, 0);
    chk("R1 alert", alert, 0);
    rst_n = 1'b1;
    // single-sector sweep: every count, both flags, threshold at and above max
    for (int c = 0; c < 64; c++)
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 2; k++) begin
          int s = (c > SAT) ? SAT : c;
          sec_cnt[0] = c; sec_unc[0] = u[0];
          run_txn(1, (s + k) & SAT, k[0], u[0], 1'b0);
        end
    // multi-sector patterns, R7 stray sectors before start
    for (int n = 0; n < 400; n++) begin
      int ns = 1 + (rnd() % 8);
      for (int i = 0; i < ns; i++) begin
        sec_cnt[i] = (rnd() & 1) ? int'(rnd() % 64) : int'(rnd() % 4);
        sec_unc[i] = (rnd() % 6) == 0;
      end
      run_txn(ns, int'(rnd() % 16), rnd() & 1, rnd() & 1, rnd() & 1);
    end
    done = 1'b1;
    summary();
  end
endmodule